// File: doc/BRIEF.md
# Periodic Compare Timer with Free-Running Counters

This block generates periodic interrupt events from two free-running time bases. Each time base is a counter advanced by its own programmable prescaler. Four compare units each watch one of the two counters. When the watched counter reaches a unit's compare value, the unit raises a sticky event flag. In the same step it advances its compare value by a stored period. The counters are never cleared by a match, so each unit keeps a constant event rate, and several units can share one time base without disturbing each other.

Software sets up the block through a write-only register port. It can start and stop each counter, set the prescaler dividers, choose the counter each unit watches, load the period and compare values, enable each unit's interrupt and clear flags by writing ones. A unit's interrupt output is high while its flag and its enable are both set. A newly written period applies from the next match onward, so the event in progress is not disturbed. A direct write to a compare value takes effect at once. If the counter has already passed that value, the unit waits for the counter to wrap around before it matches.

Top module: `periodic_compare_timer`

## Requirements
- R1: While started, a counter advances by exactly one per prescaler period and wraps from all ones to zero. A compare match never resets a counter, so successive events of one unit stay exactly one period apart.
- R2: A prescaler setting of D makes its counter advance once every D+1 clock cycles. The setting for counter 0 is at address 1 and the setting for counter 1 is at address 2.
- R3: On a match, a unit's compare value becomes the old compare value plus the unit's period. A match is the cycle in which the watched counter advances to a value equal to the compare value.
- R4: The period of unit k is written at address 12+k. A write to it does not move the current compare value. The new period is first used at the next match.
- R5: The compare value of unit k is written at address 8+k and takes effect at once. If the counter has already passed the new value, the next match comes only after the counter wraps.
- R6: Bit k of the source register (address 3) selects the counter for unit k: 0 means counter 0 and 1 means counter 1.
- R7: Unit k owns bit k (weight 2^k) of the enable register (address 4), of the flag-clear write (address 5) and of the `irq` output. `irq[k]` equals flag k AND enable k.
- R8: A match sets the flag even while the unit's enable is 0. Enabling later raises `irq` at once. Clearing the flag before enabling discards the event.
- R9: Writing 1 to bit k at address 5 clears flag k, and writing 0 to a bit leaves that flag unchanged. If a clear and a match of the same unit fall in the same cycle, the flag stays set.
- R10: Bit b of address 0 starts counter b. A stopped counter holds both its prescaler and its count, and it resumes from those values when started again.
- R11: After reset all counters, prescaler settings, compare values, periods, flags, enables and start bits are zero, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 32 | Register write data |
| irq | output | 4 | Per-unit interrupt outputs |

## Verification
Two functions can act on one flag in the same clock edge: the write-one-to-clear from software and the hardware set from a new match. The bench starts counter 0 undivided with a known compare value. It then places a clear write so that its strobe edge is exactly the edge at which the counter reaches that value. The result is judged at the port: `irq[0]` must still be high after that edge, and only a second, later clear may drop it. A second same-edge case also gets a check: a period write that lands between two matches must leave the pending match where it was and must change only the interval after it.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int NCNT     = 2;
  localparam int NCMP     = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;

  localparam int ADDR_RUN      = 0;
  localparam int ADDR_PRE_BASE = 1;
  localparam int ADDR_SRC      = 3;
  localparam int ADDR_ENA      = 4;
  localparam int ADDR_CLR      = 5;
  localparam int ADDR_CMP_BASE = 8;
  localparam int ADDR_PER_BASE = 12;

  typedef struct packed {
    logic [NCMP-1:0] cmpWr;
    logic [NCMP-1:0] perWr;
    logic [NCMP-1:0] flagClr;
  } pctStrobes_t;
endpackage

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick,
  output logic [CNT_W-1:0] cntNext
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt;

  assign tick    = run && (preCnt >= div);
  assign cntNext = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (run) begin
      if (tick) begin
        preCnt <= '0;
        cnt    <= cntNext;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> ($stable(cnt) && $stable(preCnt)));

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    run |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/pct_compare.sv
module pct_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] cntNext,
  input  logic             cmpWr,
  input  logic             perWr,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] wrVal,
  output logic             flag
);
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] perReg;
  logic             match;

  assign match = tick && (cntNext == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
      perReg <= '0;
      flag   <= 1'b0;
    end else begin
      if (cmpWr)      cmpReg <= wrVal;
      else if (match) cmpReg <= cmpReg + perReg;
      if (perWr)      perReg <= wrVal;
      flag <= match | (flag & ~flagClr);
    end
  end

  assert_reload_adds_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    (match && !cmpWr) |=> (cmpReg == $past(cmpReg) + $past(perReg)));

  assert_period_write_keeps_compare_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!match && !cmpWr) |=> $stable(cmpReg));

  assert_match_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    match |=> flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import pct_pkg::*;
#(
  parameter int PRE_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NCMP-1:0]            flags,
  output pctStrobes_t                strobes,
  output logic [NCNT-1:0]            runCnt,
  output logic [NCNT-1:0][PRE_W-1:0] preDiv,
  output logic [NCMP-1:0]            srcSel,
  output logic [NCMP-1:0]            irq
);
  logic [NCMP-1:0] enaReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      srcSel <= '0;
      enaReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_RUN)) runCnt <= wrData[NCNT-1:0];
      if (wrAddr == ADDR_W'(ADDR_SRC)) srcSel <= wrData[NCMP-1:0];
      if (wrAddr == ADDR_W'(ADDR_ENA)) enaReg <= wrData[NCMP-1:0];
    end
  end

  for (genvar b = 0; b < NCNT; b++) begin : g_pre
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) preDiv[b] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(ADDR_PRE_BASE + b)) preDiv[b] <= wrData[PRE_W-1:0];
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_strb
    always_comb begin
      strobes.cmpWr[k]   = wrEn && (wrAddr == ADDR_W'(ADDR_CMP_BASE + k));
      strobes.perWr[k]   = wrEn && (wrAddr == ADDR_W'(ADDR_PER_BASE + k));
      strobes.flagClr[k] = wrEn && (wrAddr == ADDR_W'(ADDR_CLR)) && wrData[k];
    end
  end

  assign irq = flags & enaReg;

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cmpWr, strobes.perWr}));

  assert_start_needs_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(runCnt));
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pctStrobes_t                strobes,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NCNT-1:0]            runCnt,
  input  logic [NCNT-1:0][PRE_W-1:0] preDiv,
  input  logic [NCMP-1:0]            srcSel,
  output logic [NCMP-1:0]            flags
);
  logic [NCNT-1:0]            tickAll;
  logic [NCNT-1:0][CNT_W-1:0] nextAll;

  for (genvar b = 0; b < NCNT; b++) begin : g_cnt
    pct_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .run     (runCnt[b]),
      .div     (preDiv[b]),
      .tick    (tickAll[b]),
      .cntNext (nextAll[b])
    );
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    pct_compare #(.CNT_W(CNT_W)) i_cmp (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (tickAll[srcSel[k]]),
      .cntNext (nextAll[srcSel[k]]),
      .cmpWr   (strobes.cmpWr[k]),
      .perWr   (strobes.perWr[k]),
      .flagClr (strobes.flagClr[k]),
      .wrVal   (wrData[CNT_W-1:0]),
      .flag    (flags[k])
    );
  end
endmodule

// File: rtl/periodic_compare_timer.sv
module periodic_compare_timer
  import pct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NCMP-1:0]   irq
);
  pctStrobes_t                strobes;
  logic [NCNT-1:0]            runCnt;
  logic [NCNT-1:0][PRE_W-1:0] preDiv;
  logic [NCMP-1:0]            srcSel;
  logic [NCMP-1:0]            flags;

  pct_ctrl #(.PRE_W(PRE_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .flags   (flags),
    .strobes (strobes),
    .runCnt  (runCnt),
    .preDiv  (preDiv),
    .srcSel  (srcSel),
    .irq     (irq)
  );

  pct_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .runCnt  (runCnt),
    .preDiv  (preDiv),
    .srcSel  (srcSel),
    .flags   (flags)
  );

  assert_irq_only_with_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~flags) == '0);
endmodule

// File: tb/test_periodic_compare_timer.sv
module test_periodic_compare_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  irq;

  int cyc = 0;
  int t0 = 0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  periodic_compare_timer #(.CNT_W(8), .PRE_W(8)) i_periodic_compare_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .irq(irq)
  );

  // unit, source, divider, compare, period, first event, second event
  localparam int VEC [4][7] = '{
    '{0, 0, 0,  5, 7,  5, 12},
    '{1, 1, 1,  3, 4,  6, 14},
    '{2, 0, 7,  2, 3, 16, 40},
    '{3, 1, 2, 10, 1, 30, 33}
  };

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 32'(d);
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic startAt(input int mask);
    wr(0, mask);
    t0 = cyc;
  endtask

  task automatic waitRise(input int k, input int limit, output int dt);
    dt = cyc - t0;
    while (irq[k] == 1'b0 && dt < limit) begin
      @(posedge clk); #2;
      dt = cyc - t0;
    end
  endtask

  task automatic waitUntil(input int n);
    while (cyc - t0 < n) begin
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int dt;
    // R11: reset state
    doReset();
    check("R11 irq after reset", int'(irq), 0);
    wr(4, 15);
    startAt(3);
    waitUntil(20);
    check("R11 zero compare not matched before wrap", int'(irq), 0);

    // Vector table: R1 R2 R3 R6 R7
    for (int v = 0; v < 4; v++) begin
      int u, s, dv, c, p;
      u = VEC[v][0]; s = VEC[v][1]; dv = VEC[v][2]; c = VEC[v][3]; p = VEC[v][4];
      doReset();
      wr(1, dv); wr(2, dv);
      wr(3, s << u);
      wr(4, 1 << u);
      wr(8 + u, c);
      wr(12 + u, p);
      startAt(1 << s);
      waitRise(u, 600, dt);
      check("R2 R6 first event cycle", dt, VEC[v][5]);
      check("R7 one-hot irq weight", int'(irq), 1 << u);
      wr(5, 1 << u);
      waitRise(u, 600, dt);
      check("R1 R3 second event cycle", dt, VEC[v][6]);
    end

    // R4: period write applies from the next match
    doReset();
    wr(4, 1); wr(8, 4); wr(12, 5);
    startAt(1);
    wr(12, 10);
    waitRise(0, 100, dt);
    check("R4 pending match unchanged", dt, 4);
    wr(5, 1);
    waitRise(0, 100, dt);
    check("R4 new period used after match", dt, 14);
    wr(5, 1);
    waitRise(0, 100, dt);
    check("R4 new period kept", dt, 24);

    // R5 R1: direct compare write behind the counter waits for wrap
    doReset();
    wr(4, 2); wr(9, 100); wr(13, 50);
    startAt(1);
    waitUntil(20);
    wr(9, 10);
    waitRise(1, 600, dt);
    check("R5 R1 match only after wrap", dt, 266);

    // R8: flag set while disabled
    doReset();
    wr(10, 3); wr(14, 100);
    startAt(1);
    waitUntil(10);
    check("R8 irq low while disabled", int'(irq), 0);
    wr(4, 4);
    check("R8 enable exposes held flag", int'(irq), 4);
    wr(5, 11);
    check("R9 zero bits leave flag", int'(irq), 4);
    wr(4, 0); wr(5, 4); wr(4, 4);
    check("R8 cleared before enable discards", int'(irq), 0);

    // R9: clear and match on the same edge
    doReset();
    wr(4, 1); wr(8, 10); wr(12, 20);
    startAt(1);
    waitUntil(9);
    wr(5, 1);
    #1;
    check("R9 match wins over clear", int'(irq[0]), 1);
    wr(5, 1);
    check("R9 later clear drops flag", int'(irq[0]), 0);

    // R10: stop holds the count
    doReset();
    wr(4, 8); wr(11, 10); wr(15, 100);
    startAt(1);
    waitUntil(5);
    wr(0, 0);
    t0 = cyc;
    waitUntil(30);
    check("R10 no event while stopped", int'(irq), 0);
    startAt(1);
    waitRise(3, 100, dt);
    check("R10 resumes from held count", dt, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule